// File: doc/BRIEF.md
# Multi-Source Reset Delay Generator

This block turns a set of digital health flags into a clean, active-low system reset. It watches a primary supply-good flag, a secondary sense-good flag and an active-low manual reset request. As soon as any of them reports a bad condition, reset is driven low. Reset is let go only after every source has stayed good for a programmable number of clock cycles. If a source goes bad again while that countdown is running, the countdown starts over.

With a build-time parameter the block provides two independent reset outputs instead of one. The first follows the supply flag and the second follows the sense flag. Manual reset gates both, and each output has its own release timer. A separate power-fail output copies its own flag through the input synchronizer only. It adds no release delay, and it never takes part in any reset decision.

Every input is asynchronous and passes through a two-stage synchronizer before the rest of the logic uses it. The block's own power-on reset clears all state. While that reset is applied, and afterwards until good inputs have worked their way through, every output reads low.

Top module: `rstgen_top`

## Requirements
- R1: In single-output mode, `rst_n_o` and `rst2_n_o` are both high only while `supply_ok_i`, `sense_ok_i` and `man_req_n_i` are all high (1 = good, manual request active low). In every other case they are low.
- R2: Take the first rising edge that samples all inputs good and count it as edge 1. Reset goes high right after edge DELAY_CYCLES+2, provided the inputs stay good at every sampling edge up to and including edge DELAY_CYCLES.
- R3: If a rising edge samples any reset source as bad, the reset output is low right after the second rising edge that follows it. This latency does not depend on DELAY_CYCLES.
- R4: Reset stays low for as long as `man_req_n_i` is low. After `man_req_n_i` returns high, reset goes high only once the full release delay of R2 has elapsed.
- R5: In dual-output mode (DUAL_OUT=1), `rst_n_o` depends only on `supply_ok_i` and `man_req_n_i`, and `rst2_n_o` depends only on `sense_ok_i` and `man_req_n_i`. Each output follows the timing of R2 and R3 on its own.
- R6: `pfail_n_o` shows the value of `pfail_ok_i` that was sampled one rising edge earlier, with no release delay added. `pfail_ok_i` has no effect on either reset output.
- R7: A manual request that is low for a single clock cycle is recognised. It asserts reset, and the full release delay then follows.
- R8: If any source goes bad while the release countdown is running, the countdown restarts from zero. Reset is released only after DELAY_CYCLES consecutive good cycles.
- R9: While `por_n` is low, all three outputs are low and the release counters are cleared.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Block clock |
| por_n | input | 1 | Block power-on reset, active low, asynchronous |
| supply_ok_i | input | 1 | Primary supply good flag, 1 = good |
| sense_ok_i | input | 1 | Secondary sense good flag, 1 = good |
| man_req_n_i | input | 1 | Manual reset request, active low |
| pfail_ok_i | input | 1 | Power-fail comparator flag, 1 = above threshold |
| rst_n_o | output | 1 | Reset output (combined, or supply channel in dual mode), active low |
| rst2_n_o | output | 1 | Second reset output (copy of rst_n_o, or sense channel in dual mode), active low |
| pfail_n_o | output | 1 | Undelayed power-fail output, low = fail |

## Verification
The hardest case to reach is a source that drops for a single cycle close to the end of a countdown. Without a reset to the counter, that glitch would be absorbed, and reset would be released too early. The stimulus builds this case on purpose: it holds all sources good for a few cycles less than the delay, then drops one source for one cycle. A single-cycle manual pulse during the released state is driven as well. These directed cases are mixed with random hold lengths, some shorter and some longer than the delay. Both output modes run side by side on the same inputs and are compared against a run-length model in the bench.

// File: rtl/rstgen_pkg.sv
package rstgen_pkg;

    // Bit positions of the sources inside the synchronized source vector
    typedef enum int unsigned {
        SRC_SUPPLY = 0,
        SRC_SENSE  = 1,
        SRC_MAN    = 2,
        SRC_PFAIL  = 3
    } src_e;

    localparam int unsigned NUM_SRC = 4;

    // Width of a counter that must hold values 0..limit
    function automatic int unsigned cnt_width(input int unsigned limit);
        return (limit < 2) ? 1 : $clog2(limit + 1);
    endfunction

endpackage

// File: rtl/rstgen_sync.sv
module rstgen_sync #(
    parameter int unsigned W       = 4,
    parameter int unsigned STAGES  = 2,
    parameter logic [W-1:0] RST_VAL = '0
) (
    input  logic         clk,
    input  logic         por_n,
    input  logic [W-1:0] d_i,
    output logic [W-1:0] q_o
);

    typedef struct packed {
        logic [STAGES-1:0][W-1:0] st;
    } sync_t;

    sync_t sync_d, sync_q;

    always_comb begin
        sync_d       = sync_q;
        sync_d.st[0] = d_i;
        for (int i = 1; i < STAGES; i++) begin
            sync_d.st[i] = sync_q.st[i-1];
        end
    end

    always_ff @(posedge clk or negedge por_n) begin
        if (!por_n) begin
            sync_q <= {STAGES{RST_VAL}};
        end else begin
            sync_q <= sync_d;
        end
    end

    assign q_o = sync_q.st[STAGES-1];

    initial begin
        stages_min_chk: assert (STAGES >= 2);
    end

endmodule

// File: rtl/rstgen_hold.sv
module rstgen_hold #(
    parameter int unsigned LIMIT = 32,
    parameter int unsigned CW    = rstgen_pkg::cnt_width(LIMIT)
) (
    input  logic clk,
    input  logic por_n,
    input  logic good_i,
    output logic rst_n_o
);

    localparam logic [CW-1:0] LAST_CNT = CW'(LIMIT - 1);
    localparam logic [CW-1:0] MAX_CNT  = CW'(LIMIT);

    typedef struct packed {
        logic [CW-1:0] cnt;
        logic          rst_n;
    } hold_t;

    hold_t hold_d, hold_q;

    always_comb begin
        hold_d = hold_q;
        if (!good_i) begin
            hold_d.cnt   = '0;
            hold_d.rst_n = 1'b0;
        end else if (!hold_q.rst_n) begin
            hold_d.cnt = hold_q.cnt + 1'b1;
            if (hold_q.cnt == LAST_CNT) begin
                hold_d.rst_n = 1'b1;
            end
        end
    end

    always_ff @(posedge clk or negedge por_n) begin
        if (!por_n) begin
            hold_q <= '0;
        end else begin
            hold_q <= hold_d;
        end
    end

    assign rst_n_o = hold_q.rst_n;

    // R3
    assert_fast_chk: assert property (@(posedge clk) disable iff (!por_n)
        !good_i |=> !hold_q.rst_n);

    // R8
    restart_chk: assert property (@(posedge clk) disable iff (!por_n)
        !good_i |=> (hold_q.cnt == '0));

    // R2
    release_delay_chk: assert property (@(posedge clk) disable iff (!por_n)
        $rose(hold_q.rst_n) |-> ($past(hold_q.cnt) == LAST_CNT));

    // R2
    no_overflow_chk: assert property (@(posedge clk) disable iff (!por_n)
        hold_q.cnt <= MAX_CNT);

endmodule

// File: rtl/rstgen_top.sv
module rstgen_top
    import rstgen_pkg::*;
#(
    parameter int unsigned DELAY_CYCLES = 32_500_000,
    parameter bit          DUAL_OUT     = 1'b0,
    parameter int unsigned SYNC_STAGES  = 2
) (
    input  logic clk,
    input  logic por_n,
    input  logic supply_ok_i,
    input  logic sense_ok_i,
    input  logic man_req_n_i,
    input  logic pfail_ok_i,
    output logic rst_n_o,
    output logic rst2_n_o,
    output logic pfail_n_o
);

    logic [NUM_SRC-1:0] src_raw;
    logic [NUM_SRC-1:0] src_s;

    always_comb begin
        src_raw             = '0;
        src_raw[SRC_SUPPLY] = supply_ok_i;
        src_raw[SRC_SENSE]  = sense_ok_i;
        src_raw[SRC_MAN]    = man_req_n_i;
        src_raw[SRC_PFAIL]  = pfail_ok_i;
    end

    // Reset value 0: every source reads as bad until real samples arrive
    rstgen_sync #(
        .W       (NUM_SRC),
        .STAGES  (SYNC_STAGES),
        .RST_VAL ('0)
    ) u_sync (
        .clk   (clk),
        .por_n (por_n),
        .d_i   (src_raw),
        .q_o   (src_s)
    );

    generate
        if (DUAL_OUT) begin : g_dual
            logic good_sup, good_sen;
            assign good_sup = src_s[SRC_SUPPLY] & src_s[SRC_MAN];
            assign good_sen = src_s[SRC_SENSE]  & src_s[SRC_MAN];

            rstgen_hold #(.LIMIT(DELAY_CYCLES)) u_hold_sup (
                .clk     (clk),
                .por_n   (por_n),
                .good_i  (good_sup),
                .rst_n_o (rst_n_o)
            );

            rstgen_hold #(.LIMIT(DELAY_CYCLES)) u_hold_sen (
                .clk     (clk),
                .por_n   (por_n),
                .good_i  (good_sen),
                .rst_n_o (rst2_n_o)
            );

            // R5
            sup_only_chk: assert property (@(posedge clk) disable iff (!por_n)
                rst_n_o |-> $past(src_s[SRC_SUPPLY] & src_s[SRC_MAN]));

            // R5
            sen_only_chk: assert property (@(posedge clk) disable iff (!por_n)
                rst2_n_o |-> $past(src_s[SRC_SENSE] & src_s[SRC_MAN]));
        end else begin : g_single
            logic good_all;
            assign good_all = src_s[SRC_SUPPLY] & src_s[SRC_SENSE] & src_s[SRC_MAN];

            rstgen_hold #(.LIMIT(DELAY_CYCLES)) u_hold_all (
                .clk     (clk),
                .por_n   (por_n),
                .good_i  (good_all),
                .rst_n_o (rst_n_o)
            );

            assign rst2_n_o = rst_n_o;

            // R1
            all_good_chk: assert property (@(posedge clk) disable iff (!por_n)
                rst_n_o |-> $past(src_s[SRC_SUPPLY] & src_s[SRC_SENSE] & src_s[SRC_MAN]));
        end
    endgenerate

    assign pfail_n_o = src_s[SRC_PFAIL];

    // R6
    pfail_follow_chk: assert property (@(posedge clk) disable iff (!por_n)
        $rose(pfail_n_o) |-> $past(src_raw[SRC_PFAIL], 2));

endmodule

// File: tb/rstgen_top_test.sv
module rstgen_top_test;

    localparam int unsigned D = 20;

    logic clk = 1'b0;
    logic por_n = 1'b0;
    logic sup = 1'b0, sen = 1'b0, man = 1'b1, pf = 1'b0;

    logic r_s, r2_s, pf_s, r_d, r2_d, pf_d;

    int checks = 0;
    int errors = 0;
    bit done = 1'b0;
    string cur_tag = "R1";

    int run_all[3];
    int run_a[3];
    int run_b[3];
    logic pfh[2];

    always #2 clk = ~clk;

    rstgen_top #(.DELAY_CYCLES(D), .DUAL_OUT(1'b0)) uut (
        .clk(clk), .por_n(por_n), .supply_ok_i(sup), .sense_ok_i(sen),
        .man_req_n_i(man), .pfail_ok_i(pf),
        .rst_n_o(r_s), .rst2_n_o(r2_s), .pfail_n_o(pf_s));

    rstgen_top #(.DELAY_CYCLES(D), .DUAL_OUT(1'b1)) uut_dual (
        .clk(clk), .por_n(por_n), .supply_ok_i(sup), .sense_ok_i(sen),
        .man_req_n_i(man), .pfail_ok_i(pf),
        .rst_n_o(r_d), .rst2_n_o(r2_d), .pfail_n_o(pf_d));

    function automatic int next_run(input int prev, input logic good);
        if (!good) return 0;
        return (prev >= int'(D) + 4) ? prev : prev + 1;
    endfunction

    function automatic logic released(input int run);
        return run >= int'(D);
    endfunction

    task automatic check(input string tag, input string what, input logic act, input logic exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: %s got %0b expected %0b", tag, what, act, exp);
        end
    endtask

    task automatic record_sample();
        run_all[2] = run_all[1]; run_all[1] = run_all[0];
        run_a[2]   = run_a[1];   run_a[1]   = run_a[0];
        run_b[2]   = run_b[1];   run_b[1]   = run_b[0];
        pfh[1]     = pfh[0];
        run_all[0] = next_run(run_all[1], sup & sen & man);
        run_a[0]   = next_run(run_a[1], sup & man);
        run_b[0]   = next_run(run_b[1], sen & man);
        pfh[0]     = pf;
    endtask

    // One clock: check outputs after the last edge, then drive new inputs
    task automatic step(input logic s_v, input logic se_v, input logic m_v, input logic p_v);
        @(negedge clk);
        check(cur_tag, "single rst_n_o", r_s, released(run_all[2]));
        check(cur_tag, "single rst2_n_o", r2_s, released(run_all[2]));
        check("R5", "dual rst_n_o", r_d, released(run_a[2]));
        check("R5", "dual rst2_n_o", r2_d, released(run_b[2]));
        check("R6", "single pfail_n_o", pf_s, pfh[1]);
        check("R6", "dual pfail_n_o", pf_d, pfh[1]);
        sup = s_v; sen = se_v; man = m_v; pf = p_v;
        record_sample();
    endtask

    task automatic hold(input int n, input logic s_v, input logic se_v, input logic m_v, input logic p_v);
        for (int i = 0; i < n; i++) step(s_v, se_v, m_v, p_v);
    endtask

    initial begin
        #(4 * 200000);
        errors++;
        $display("FAIL watchdog: run did not complete got 0 expected 1");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        void'($urandom(32'd20240611));
        // R9: outputs low while block reset is applied
        sup = 1'b1; sen = 1'b1; man = 1'b1; pf = 1'b1;
        repeat (4) @(posedge clk);
        @(negedge clk);
        check("R9", "rst_n_o in por", r_s, 1'b0);
        check("R9", "rst2_n_o in por", r2_s, 1'b0);
        check("R9", "pfail_n_o in por", pf_s, 1'b0);
        check("R9", "dual rst_n_o in por", r_d, 1'b0);
        check("R9", "dual rst2_n_o in por", r2_d, 1'b0);

        // release block reset with all sources good; R2 release timing
        por_n = 1'b1;
        run_all = '{0, 0, 0}; run_a = '{0, 0, 0}; run_b = '{0, 0, 0};
        pfh[0] = 1'b0; pfh[1] = 1'b0;
        run_all[0] = next_run(0, sup & sen & man);
        run_a[0]   = next_run(0, sup & man);
        run_b[0]   = next_run(0, sen & man);
        pfh[0]     = pf;
        cur_tag = "R2";
        hold(D + 6, 1, 1, 1, 1);

        // R3: supply drops, then sense drops
        cur_tag = "R3";
        hold(5, 0, 1, 1, 1);
        hold(D + 6, 1, 1, 1, 1);
        hold(3, 1, 0, 1, 1);
        hold(D + 6, 1, 1, 1, 1);

        // R4: manual request held low, then released
        cur_tag = "R4";
        hold(8, 1, 1, 0, 1);
        hold(D + 6, 1, 1, 1, 1);

        // R7: single-cycle manual pulse
        cur_tag = "R7";
        hold(1, 1, 1, 0, 1);
        hold(D + 6, 1, 1, 1, 1);

        // R8: one-cycle glitch near end of countdown restarts it
        cur_tag = "R8";
        hold(3, 0, 0, 1, 1);
        hold(D - 3, 1, 1, 1, 1);
        hold(1, 1, 0, 1, 1);
        hold(D + 6, 1, 1, 1, 1);
        hold(D - 1, 1, 1, 1, 1);
        hold(1, 1, 1, 0, 1);
        hold(D + 6, 1, 1, 1, 1);

        // R6: power-fail toggles freely while resets are released
        cur_tag = "R6";
        for (int i = 0; i < 60; i++) step(1, 1, 1, logic'($urandom_range(0, 1)));

        // R1: random source patterns with random hold lengths
        cur_tag = "R1";
        for (int ph = 0; ph < 300; ph++) begin
            logic s_v, se_v, m_v;
            int len;
            s_v  = ($urandom_range(0, 7) != 0);
            se_v = ($urandom_range(0, 7) != 0);
            m_v  = ($urandom_range(0, 7) != 0);
            len  = $urandom_range(1, D + 8);
            for (int c = 0; c < len; c++) step(s_v, se_v, m_v, logic'($urandom_range(0, 1)));
        end

        done = 1'b1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

endmodule